// File: doc/BRIEF.md
# Two-Write Two-Read Banked RAM

This block is a synchronous memory that accepts two independent writes and serves two independent reads on every clock edge. It is built from four simple dual-port banks, each with one write port and one read port. Every writer owns two banks and stores each word in both of them. Every reader has one bank from each writer's pair available. A one-bit-per-address selector then tells the reader which writer touched that address most recently.

The selector is split into two one-bit tables, one per writer. Each writer updates only its own table. When writer A writes, it copies writer B's bit for that address into its own table. When writer B writes, it stores the inverse of writer A's bit. A reader compares the two bits. If they are equal, the A-side bank holds the newest value; if they differ, the B-side bank does. Nothing in the block arbitrates or stalls. Every port is accepted on every cycle, so there is no back-pressure. The one rule the caller must follow is that both writers never target the same address in the same cycle.

Top module: `twin_writer_ram`

## Requirements
- R1: When both write enables are high with distinct addresses, both words are stored in that cycle, and later reads of either address return its word.
- R2: Read data for an address presented at a clock edge appears on the matching read data output after that edge and holds until the next edge.
- R3: Under arbitrary interleaved traffic from both writers, each reader returns the word most recently written to the address, whichever writer wrote it.
- R4: A write through port A makes the two selector bits at that address equal, so readers then take the A-side bank.
- R5: A write through port B makes the two selector bits at that address differ, so readers then take the B-side bank.
- R6: Each reader returns the A-side bank word when the two selector bits are equal, and the B-side bank word when they differ; reader C and reader D agree on the same address.
- R7: A read of an address that is written at the same clock edge returns the value held before that write.
- R8: Reset clears both selector tables but not the banks, so after reset every address reads the last word written through port A.
- R9: While reset is asserted, both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| wa_en | input | 1 | Write enable, writer A |
| wa_addr | input | AW | Write address, writer A |
| wa_data | input | DW | Write data, writer A |
| wb_en | input | 1 | Write enable, writer B |
| wb_addr | input | AW | Write address, writer B |
| wb_data | input | DW | Write data, writer B |
| rc_addr | input | AW | Read address, reader C |
| rc_data | output | DW | Read data, reader C, one cycle after its address |
| rd_addr | input | AW | Read address, reader D |
| rd_data | output | DW | Read data, reader D, one cycle after its address |

## Verification
The assertions take for granted that the two writers never present the same address with both enables high in one cycle. The selector checks and the read-hold checks depend on this, and a dedicated check flags any violation. The random stimulus respects the rule by drawing writer B's address again whenever it equals writer A's. Reads compare only against addresses the reference model has already seen written on the side it expects to serve the read. As a result, uninitialised bank contents never enter a comparison.

// File: rtl/twin_writer_ram_pkg.sv
package twin_writer_ram_pkg;
  localparam int unsigned NPORT = 2;
  typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;
endpackage

// File: rtl/twr_bank.sv
module twr_bank #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read sees the array before this edge's write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/twr_sel_table.sv
module twr_sel_table #(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned AW     = $clog2(DEPTH),
  parameter bit          INVERT = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic                other_bit,
  input  logic [AW-1:0]       peer_addr,
  output logic                peer_bit,
  input  logic [1:0][AW-1:0]  raddr,
  output logic [1:0]          rbit
);
  logic [DEPTH-1:0] tbl;
  logic             nbit;

  generate
    if (INVERT) begin : g_inv
      assign nbit = ~other_bit;
    end else begin : g_copy
      assign nbit = other_bit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  tbl <= '0;
    else if (we) tbl[waddr] <= nbit;
  end

  assign peer_bit = tbl[peer_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbit <= '0;
    else begin
      for (int i = 0; i < 2; i++) rbit[i] <= tbl[raddr[i]];
    end
  end

  // R4 R5
  tbl_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> tbl[$past(waddr)] == $past(nbit));
endmodule

// File: rtl/twin_writer_ram.sv
module twin_writer_ram
  import twin_writer_ram_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  input  logic [AW-1:0] rc_addr,
  output logic [DW-1:0] rc_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [NPORT-1:0]                  wr_en;
  logic [NPORT-1:0][AW-1:0]          wr_addr;
  logic [NPORT-1:0][DW-1:0]          wr_data;
  logic [NPORT-1:0][AW-1:0]          rd_a;
  logic [NPORT-1:0][DW-1:0]          rd_out;
  logic [NPORT-1:0][NPORT-1:0][DW-1:0] bank_q;  // [writer][reader]
  logic [NPORT-1:0][NPORT-1:0]       sel_q;   // [writer][reader]
  logic [NPORT-1:0]                  peer_bit;

  assign wr_en   = {wb_en, wa_en};
  assign wr_addr = {wb_addr, wa_addr};
  assign wr_data = {wb_data, wa_data};
  assign rd_a    = {rd_addr, rc_addr};
  assign rc_data = rd_out[0];
  assign rd_data = rd_out[1];

  genvar w, r;
  generate
    for (w = 0; w < NPORT; w++) begin : g_w
      for (r = 0; r < NPORT; r++) begin : g_r
        twr_bank #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_bank (
          .clk(clk), .rst_n(rst_n),
          .we(wr_en[w]), .waddr(wr_addr[w]), .wdata(wr_data[w]),
          .raddr(rd_a[r]), .rdata(bank_q[w][r])
        );
      end
      twr_sel_table #(.DEPTH(DEPTH), .AW(AW), .INVERT(w == 1)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en[w]), .waddr(wr_addr[w]),
        .other_bit(peer_bit[1-w]),
        .peer_addr(wr_addr[1-w]), .peer_bit(peer_bit[w]),
        .raddr(rd_a), .rbit(sel_q[w])
      );
    end

    for (r = 0; r < NPORT; r++) begin : g_rd
      side_e side;
      always_comb begin
        side      = (sel_q[0][r] == sel_q[1][r]) ? SIDE_A : SIDE_B;
        rd_out[r] = (side == SIDE_A) ? bank_q[0][r] : bank_q[1][r];
      end

      // R7
      read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rd_a[r] == $past(rd_a[r])
         && !($past(wr_en[0]) && $past(wr_addr[0]) == rd_a[r])
         && !($past(wr_en[1]) && $past(wr_addr[1]) == rd_a[r]))
        |=> $stable(rd_out[r]));
    end
  endgenerate

  // R1
  no_wr_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_en && wb_en && wa_addr == wb_addr));

  // R4
  a_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wa_en |=> g_w[0].u_sel.tbl[$past(wa_addr)] == g_w[1].u_sel.tbl[$past(wa_addr)]);

  // R5
  b_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> g_w[0].u_sel.tbl[$past(wb_addr)] != g_w[1].u_sel.tbl[$past(wb_addr)]);
endmodule

// File: tb/twin_writer_ram_bench.sv
module twin_writer_ram_bench;
  localparam int unsigned DEPTH = 32;
  localparam int unsigned DW    = 16;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wa_en = 0, wb_en = 0;
  logic [AW-1:0] wa_addr = '0, wb_addr = '0, rc_addr = '0, rd_addr = '0;
  logic [DW-1:0] wa_data = '0, wb_data = '0;
  logic [DW-1:0] rc_data, rd_data;

  always #2 clk = ~clk;

  twin_writer_ram #(.DEPTH(DEPTH), .DW(DW)) u_twin_writer_ram (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .rc_addr(rc_addr), .rc_data(rc_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct {
    bit            chk_c, chk_d;
    logic [DW-1:0] exp_c, exp_d;
    string         tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;

  logic [DW-1:0] last_a [DEPTH];
  logic [DW-1:0] last_b [DEPTH];
  bit            seen_a [DEPTH];
  bit            seen_b [DEPTH];
  bit            side_b [DEPTH];

  task automatic cmp(string tag, string port, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s reader %s: actual %h expected %h", tag, port, act, exp);
    end
  endtask

  function automatic bit known(int a);
    return side_b[a] ? seen_b[a] : seen_a[a];
  endfunction

  function automatic logic [DW-1:0] expect_of(int a);
    return side_b[a] ? last_b[a] : last_a[a];
  endfunction

  task automatic drive(bit ea, int aa, logic [DW-1:0] da,
                       bit eb, int ab, logic [DW-1:0] db,
                       int rc, int rd, bit chk, string tag);
    item_t it;
    wa_en = ea; wa_addr = AW'(aa); wa_data = da;
    wb_en = eb; wb_addr = AW'(ab); wb_data = db;
    rc_addr = AW'(rc); rd_addr = AW'(rd);
    // expectation taken before this cycle's writes (R7)
    it.chk_c = chk && known(rc);
    it.chk_d = chk && known(rd);
    it.exp_c = expect_of(rc);
    it.exp_d = expect_of(rd);
    it.tag   = tag;
    q.push_back(it);
    if (ea) begin last_a[aa] = da; seen_a[aa] = 1; side_b[aa] = 0; end
    if (eb) begin last_b[ab] = db; seen_b[ab] = 1; side_b[ab] = 1; end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wa_en = 0; wb_en = 0;
  endtask

  // monitor: compares one queued item per cycle, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.chk_c) cmp(it.tag, "C", rc_data, it.exp_c);
        if (it.chk_d) cmp(it.tag, "D", rd_data, it.exp_d);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      seen_a[i] = 0; seen_b[i] = 0; side_b[i] = 0;
    end
    repeat (3) @(negedge clk);
    cmp("R9", "C", rc_data, '0);
    cmp("R9", "D", rd_data, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed sequence on addresses 5 and 9
    drive(1, 5, 16'h1111, 0, 0, '0, 5, 5, 0, "R1");
    drive(0, 0, '0,       0, 0, '0, 5, 5, 1, "R2");   // 1111 on both readers
    drive(0, 0, '0,       1, 5, 16'h2222, 5, 5, 1, "R7"); // old 1111
    drive(0, 0, '0,       0, 0, '0, 5, 5, 1, "R5");   // 2222 from B side
    drive(1, 5, 16'h3333, 1, 9, 16'h4444, 5, 9, 1, "R7");
    drive(0, 0, '0,       0, 0, '0, 5, 9, 1, "R1");   // 3333, 4444
    drive(0, 0, '0,       0, 0, '0, 9, 5, 1, "R4");   // A wrote 5 last
    drive(0, 0, '0,       1, 5, 16'h6666, 9, 5, 1, "R6");
    drive(0, 0, '0,       0, 0, '0, 5, 5, 1, "R6");   // 6666 both readers
    idle_inputs();
    @(negedge clk);

    // reset in mid-run: selectors cleared, banks kept
    rst_n = 1'b0;
    @(negedge clk);
    cmp("R9", "C", rc_data, '0);
    cmp("R9", "D", rd_data, '0);
    for (int i = 0; i < DEPTH; i++) side_b[i] = 0;
    rst_n = 1'b1;
    @(negedge clk);
    drive(0, 0, '0, 0, 0, '0, 5, 5, 1, "R8");   // 3333 from A bank
    drive(0, 0, '0, 0, 0, '0, 5, 5, 1, "R8");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int aa, ab;
      aa = $urandom_range(DEPTH-1);
      ab = $urandom_range(DEPTH-1);
      while (ab == aa) ab = $urandom_range(DEPTH-1);
      drive($urandom_range(1), aa, DW'($urandom),
            $urandom_range(1), ab, DW'($urandom),
            $urandom_range(DEPTH-1), $urandom_range(DEPTH-1), 1, "R3");
    end
    idle_inputs();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule